// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power states of a small microcontroller. Software programs a mode field and a wake qualification count in one control register and a wake-source mask in a second register. When the core issues an idle request, the block leaves its running state and enters one of three low-power states. Each state has its own clock-gating profile, driven on three enables: the oscillator, the CPU clock input and the system clock output. The block then watches the wake sources that state allows and brings the device back to normal operation.

The states are RUN, IDLE, STBY (standby), HALT, OSCW (waiting for the oscillator to restart after HALT) and WAKE (a single cycle that ends every low-power episode). The transitions are as follows:

- RUN→IDLE, RUN→STBY and RUN→HALT happen on an idle request, selected by the mode field.
- IDLE→WAKE happens on a watchdog interrupt, any enabled interrupt, the non-maskable interrupt (NMI) or a debugger request.
- STBY→WAKE happens on a watchdog interrupt, a debugger request or a qualified masked source.
- HALT→OSCW happens on NMI or a debugger request.
- OSCW→WAKE happens when the oscillator reports that it is stable.
- WAKE→RUN happens unconditionally.
- Reset from any state forces RUN.

The block runs entirely on the free-running oscillator clock. The clock sources, watchdog and interrupt controller are outside the block and appear only as inputs. General-purpose outputs are not touched by the block, so they keep their values across every episode.

Top module: `lpm_ctrl`

## Requirements
- R1: In RUN, a high `idle_req` samples control bits [1:0]. Value 00 enters IDLE, 01 enters STBY, and 10 or 11 enters HALT. The new state is reached at the next clock edge.
- R2: In IDLE all three enables are 1. A high `wd_int`, `irq_any`, `nmi` or `dbg_req` leads to WAKE at the next edge.
- R3: In STBY, `osc_en` is 1 and `cpu_clk_en` and `sys_clk_en` are 0.
- R4: In STBY the candidate vector is {`wake_src`[6:0], `nmi`}, so `nmi` is bit 0 and `wake_src`[k] is bit k+1. Only candidates whose bit is set in the mask register can wake the device. Unselected candidates and `irq_any` are ignored, and the state stays STBY.
- R5: Control bits [7:2] hold a qualification count Q. STBY is left for WAKE on the (Q+1)-th consecutive clock edge at which a selected candidate is high. If the selected candidates all drop, the count restarts from zero.
- R6: In STBY, `wd_int` or `dbg_req` leads to WAKE at the next edge, whatever the mask.
- R7: In HALT all three enables are 0. Only `nmi` or `dbg_req` leave HALT. `irq_any`, `wd_int` and `wake_src` are ignored.
- R8: After leaving HALT, the block sits in OSCW with `osc_en`=1 and both CPU-side enables 0 until `osc_stable` is high. It then moves to WAKE at the next edge.
- R9: `wake_done` is high for exactly one cycle, in WAKE, with all enables at 1. RUN follows.
- R10: An active-low `rst_n` asynchronously forces RUN with all enables at 1 and `wake_done` at 0. It also clears the mode, the count and the mask to zero.
- R11: In RUN without `idle_req`, the wake inputs have no effect: `wake_done` stays 0 and all enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control (mode, count), 1 = wake mask |
| reg_wdata | input | 8 | Write data |
| idle_req | input | 1 | Idle request from the core |
| wd_int | input | 1 | Watchdog interrupt |
| irq_any | input | 1 | Any enabled interrupt |
| nmi | input | 1 | Non-maskable interrupt |
| dbg_req | input | 1 | Debugger wake request |
| wake_src | input | 7 | Standby wake candidates (external interrupt, trips, receive pins) |
| osc_stable | input | 1 | Oscillator has settled |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock input enable |
| sys_clk_en | output | 1 | System clock output enable |
| wake_done | output | 1 | One-cycle pulse on return to run |

## Verification
The enables follow the state directly, so they are valid one edge after `idle_req` or a register-free event. `wake_done` is due one edge after an IDLE or unconditional STBY wake, Q+1 edges after a qualified source rises, and two edges after a HALT wake when the oscillator is already stable. The bench drives every input on the falling edge. It counts rising edges from the stimulus until `wake_done` appears and compares that count with these figures. Reset effects are sampled one time unit after `rst_n` falls.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_STBY,
        ST_HALT,
        ST_OSCW,
        ST_WAKE
    } lpm_state_e;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
    parameter int QW = 6,
    parameter int NW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [1:0]    mode,
    output logic [QW-1:0] qual,
    output logic [NW-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            qual <= '0;
            mask <= '0;
        end else if (wr) begin
            if (addr) begin
                mask <= wdata[NW-1:0];
            end else begin
                mode <= wdata[1:0];
                qual <= wdata[QW+1:2];
            end
        end
    end

endmodule

// File: rtl/lpm_qual.sv
module lpm_qual #(
    parameter int QW = 6,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] cand,
    input  logic [NW-1:0] mask,
    input  logic [QW-1:0] limit,
    output logic          qual_ok
);

    logic [NW-1:0] hit;
    logic          sel;
    logic [QW-1:0] cnt;

    for (genvar i = 0; i < NW; i++) begin : g_hit
        assign hit[i] = cand[i] & mask[i];
    end

    assign sel = |hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || !sel) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual_ok = en && sel && (cnt >= limit);

    // R5: a dropped source restarts the qualification window
    assert_qual_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel) |=> (cnt == '0));

    // R4: nothing unselected can qualify
    assert_masked_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cand & mask) == '0) |-> !qual_ok);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic [1:0] mode,
    input  logic       wd_int,
    input  logic       irq_any,
    input  logic       nmi,
    input  logic       dbg_req,
    input  logic       qual_ok,
    input  logic       osc_stable,
    output lpm_state_e state,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       sys_clk_en,
    output logic       wake_done
);

    lpm_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (idle_req) begin
                    if (mode[1])      nxt = ST_HALT;
                    else if (mode[0]) nxt = ST_STBY;
                    else              nxt = ST_IDLE;
                end
            end
            ST_IDLE: if (wd_int || irq_any || nmi || dbg_req) nxt = ST_WAKE;
            ST_STBY: if (wd_int || dbg_req || qual_ok)        nxt = ST_WAKE;
            ST_HALT: if (nmi || dbg_req)                      nxt = ST_OSCW;
            ST_OSCW: if (osc_stable)                          nxt = ST_WAKE;
            ST_WAKE: nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        osc_en     = 1'b1;
        cpu_clk_en = 1'b1;
        sys_clk_en = 1'b1;
        wake_done  = 1'b0;
        unique case (state)
            ST_RUN, ST_IDLE: ;
            ST_STBY, ST_OSCW: begin
                cpu_clk_en = 1'b0;
                sys_clk_en = 1'b0;
            end
            ST_HALT: begin
                osc_en     = 1'b0;
                cpu_clk_en = 1'b0;
                sys_clk_en = 1'b0;
            end
            ST_WAKE: wake_done = 1'b1;
            default: ;
        endcase
    end

    // R1: standby mode code selects STBY
    assert_stby_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && idle_req && mode == 2'b01) |=> (state == ST_STBY));

    // R7: HALT holds without nmi or debugger
    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !nmi && !dbg_req) |=> (state == ST_HALT));

    // R8: clocks stay gated until the oscillator is stable
    assert_oscw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OSCW && !osc_stable) |=> (!cpu_clk_en && !sys_clk_en));

    // R9: wake_done is a single-cycle pulse
    assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    // R11: RUN without idle request stays in RUN
    assert_run_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !idle_req) |=> (state == ST_RUN));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter  int NSRC = 7,
    parameter  int QW   = 6,
    localparam int NW   = NSRC + 1,
    localparam int DW   = (NW > QW + 2) ? NW : QW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            idle_req,
    input  logic            wd_int,
    input  logic            irq_any,
    input  logic            nmi,
    input  logic            dbg_req,
    input  logic [NSRC-1:0] wake_src,
    input  logic            osc_stable,
    output logic            osc_en,
    output logic            cpu_clk_en,
    output logic            sys_clk_en,
    output logic            wake_done
);

    logic [1:0]    mode;
    logic [QW-1:0] qual;
    logic [NW-1:0] mask;
    logic          qual_ok;
    lpm_state_e    state;

    lpm_regs #(.QW(QW), .NW(NW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .mode  (mode),
        .qual  (qual),
        .mask  (mask)
    );

    lpm_qual #(.QW(QW), .NW(NW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state == ST_STBY),
        .cand    ({wake_src, nmi}),
        .mask    (mask),
        .limit   (qual),
        .qual_ok (qual_ok)
    );

    lpm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req   (idle_req),
        .mode       (mode),
        .wd_int     (wd_int),
        .irq_any    (irq_any),
        .nmi        (nmi),
        .dbg_req    (dbg_req),
        .qual_ok    (qual_ok),
        .osc_stable (osc_stable),
        .state      (state),
        .osc_en     (osc_en),
        .cpu_clk_en (cpu_clk_en),
        .sys_clk_en (sys_clk_en),
        .wake_done  (wake_done)
    );

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       idle_req = 1'b0;
    logic       wd_int = 1'b0;
    logic       irq_any = 1'b0;
    logic       nmi = 1'b0;
    logic       dbg_req = 1'b0;
    logic [6:0] wake_src = '0;
    logic       osc_stable = 1'b1;
    logic       osc_en, cpu_clk_en, sys_clk_en, wake_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lpm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .idle_req(idle_req), .wd_int(wd_int),
        .irq_any(irq_any), .nmi(nmi), .dbg_req(dbg_req), .wake_src(wake_src),
        .osc_stable(osc_stable), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .sys_clk_en(sys_clk_en), .wake_done(wake_done)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [5:0] qual;
        logic [7:0] mask;
        logic [7:0] wsrc;   // bit0 -> nmi, bits7:1 -> wake_src
        logic       irq;
        logic       wd;
        logic       dbg;
        logic [2:0] en;     // {osc, cpu, sys} in the low-power state
        logic [7:0] lat;    // rising edges until wake_done
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 6'd0,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'b111, 8'd1},
        '{2'b00, 6'd0,  8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 3'b111, 8'd1},
        '{2'b00, 6'd0,  8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'b111, 8'd1},
        '{2'b00, 6'd0,  8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'b111, 8'd1},
        '{2'b01, 6'd0,  8'h02, 8'h02, 1'b0, 1'b0, 1'b0, 3'b100, 8'd1},
        '{2'b01, 6'd3,  8'h02, 8'h02, 1'b0, 1'b0, 1'b0, 3'b100, 8'd4},
        '{2'b01, 6'd5,  8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 3'b100, 8'd6},
        '{2'b01, 6'd10, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'b100, 8'd1},
        '{2'b01, 6'd2,  8'h80, 8'h80, 1'b0, 1'b0, 1'b0, 3'b100, 8'd3},
        '{2'b01, 6'd7,  8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 3'b100, 8'd1},
        '{2'b10, 6'd0,  8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000, 8'd2},
        '{2'b11, 6'd0,  8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 8'd2},
        '{2'b10, 6'd9,  8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000, 8'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int ens();
        return {29'd0, osc_en, cpu_clk_en, sys_clk_en};
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic enter();
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
    endtask

    task automatic drive(input logic [7:0] ws, input logic i, input logic w, input logic d);
        nmi = ws[0]; wake_src = ws[7:1]; irq_any = i; wd_int = w; dbg_req = d;
    endtask

    task automatic wait_wake(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wake_done && n < 100);
    endtask

    task automatic idle_cycles(input int k, input string tag, input int exp_en);
        for (int c = 0; c < k; c++) begin
            @(negedge clk);
            chk(tag, {ens(), 1'b0, wake_done}, {exp_en, 2'b00});
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset enables", ens(), 3'b111);
        chk("R10 reset wake_done", wake_done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: RUN ignores wake inputs
        drive(8'hFF, 1'b1, 1'b1, 1'b1);
        idle_cycles(4, "R11 run ignores wakes", 3'b111);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            wr(1'b0, {v.qual, v.mode});
            wr(1'b1, v.mask);
            enter();
            tag = (v.mode == 2'b00) ? "R1 R2 entry" : (v.mode == 2'b01) ? "R1 R3 entry" : "R1 R7 entry";
            chk(tag, ens(), v.en);
            drive(v.wsrc, v.irq, v.wd, v.dbg);
            wait_wake(n);
            tag = (v.mode == 2'b00) ? "R2 latency" :
                  (v.mode == 2'b01) ? ((v.wd || v.dbg) ? "R6 latency" : "R5 latency") :
                  "R7 R8 latency";
            chk(tag, n, v.lat);
            chk("R9 wake enables", ens(), 3'b111);
            drive(8'h00, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            chk("R9 pulse width", wake_done, 0);
        end

        // R4: unselected source and irq ignored in STBY
        wr(1'b0, {6'd0, 2'b01});
        wr(1'b1, 8'h02);
        enter();
        drive(8'hFD, 1'b1, 1'b0, 1'b0);
        idle_cycles(10, "R4 stby ignores unselected", 3'b100);
        drive(8'h02, 1'b0, 1'b0, 1'b0);
        wait_wake(n);
        chk("R4 selected wakes", n, 1);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        // R5: qualification restarts on a drop
        wr(1'b0, {6'd4, 2'b01});
        enter();
        drive(8'h02, 1'b0, 1'b0, 1'b0);
        idle_cycles(3, "R5 not yet qualified", 3'b100);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        idle_cycles(1, "R5 dropped", 3'b100);
        drive(8'h02, 1'b0, 1'b0, 1'b0);
        wait_wake(n);
        chk("R5 restart latency", n, 5);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        // R7: HALT ignores irq, watchdog, wake_src
        wr(1'b0, {6'd0, 2'b10});
        enter();
        drive(8'hFE, 1'b1, 1'b1, 1'b0);
        idle_cycles(8, "R7 halt ignores", 3'b000);
        // R8: oscillator wait
        osc_stable = 1'b0;
        drive(8'h01, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        chk("R8 osc wait enables", ens(), 3'b100);
        idle_cycles(5, "R8 osc wait hold", 3'b100);
        osc_stable = 1'b1;
        wait_wake(n);
        chk("R8 stable latency", n, 1);
        @(negedge clk);

        // R10: async reset during STBY clears registers
        wr(1'b0, {6'd5, 2'b01});
        wr(1'b1, 8'hFF);
        enter();
        chk("R3 before reset", ens(), 3'b100);
        rst_n = 1'b0;
        #1;
        chk("R10 async enables", ens(), 3'b111);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        enter();
        chk("R10 mode cleared", ens(), 3'b111);
        drive(8'h00, 1'b1, 1'b0, 1'b0);
        wait_wake(n);
        chk("R10 idle wake", n, 1);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        wr(1'b0, {6'd0, 2'b01});
        enter();
        drive(8'hFF, 1'b0, 1'b0, 1'b0);
        idle_cycles(6, "R10 mask cleared", 3'b100);
        drive(8'h00, 1'b0, 1'b0, 1'b1);
        wait_wake(n);
        chk("R6 debugger wake", n, 1);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule